// File: doc/BRIEF.md
# Dataflow Token ALU Stage

This block is the execution stage of a dataflow processing element. Each cycle it may receive one fired instruction: a 5-bit opcode, two 16-bit operands (A and B) and an 8-bit immediate. One clock later it presents at most one 16-bit result token, marked by a valid flag. Dyadic operations use both operands. Monadic operations read only operand A and share the same input port. The const operation takes its value from the immediate. The context-release operation consumes its input and produces no token.

Output sequencing is a two-state machine. ST_IDLE means no token is presented. ST_EMIT means a result token is presented on `out_data`. The machine has four transitions. IDLE_TO_EMIT is taken when a valid instruction that produces a result arrives. EMIT_HOLD is taken when another producing instruction follows at once. EMIT_TO_IDLE is taken when the next cycle brings no valid input, or brings a non-producing opcode. IDLE_STAY covers every other case. The result register loads only on a transition into ST_EMIT.

Top module: `tok_alu_stage`

## Requirements
- R1: After reset, `out_valid` is 0.
- R2: Add (opcode 0) outputs A+B, sub (1) outputs A-B, inc (16) outputs A+1 and dec (17) outputs A-1. All four wrap modulo 2^16.
- R3: And (2), or (3) and xor (4) are bitwise on A and B. Not (18) outputs the bitwise inverse of A.
- R4: The comparisons eq (5), lt (6), lte (7), gt (8) and gte (9) compare A with B as unsigned values. Each outputs 16'h0001 when true and 16'h0000 when false.
- R5: Left shift (21) moves A left by imm[2:0]+1 positions, so distances run from 1 to 8. Vacated bits are filled with 0.
- R6: Logical right shift (22) moves A right by imm[2:0]+1 positions and fills the vacated bits with 0.
- R7: Arithmetic right shift (23) moves A right by imm[2:0]+1 positions and fills the vacated bits with copies of A[15].
- R8: Pass (19) outputs A. Const (20) outputs the immediate, zero-extended to 16 bits.
- R9: A valid producing instruction gives `out_valid`=1 with its result in the following cycle. Back-to-back instructions give back-to-back tokens.
- R10: Free-context (24) and any unassigned opcode (10 to 15 and 25 to 31) give `out_valid`=0 in the following cycle and leave `out_data` unchanged.
- R11: When `in_valid` is 0, `out_valid` is 0 in the following cycle and `out_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fired instruction present |
| in_opcode | input | 5 | Operation code |
| in_opa | input | 16 | Operand A |
| in_opb | input | 16 | Operand B (dyadic only) |
| in_imm | input | 8 | Immediate: shift distance code or constant |
| out_valid | output | 1 | Result token present |
| out_data | output | 16 | Result token data |

## Verification
The assertions assume that the opcode, operands and immediate are known and stable whenever `in_valid` is high. They treat opcode values as meaningful only in the cycle where `in_valid` is asserted. The bench changes inputs only on the falling edge and drives a fully defined instruction each time it raises `in_valid`. Between scenarios it returns `in_valid` to 0, so every expected token can be traced to exactly one instruction.

// File: rtl/tok_alu_pkg.sv
package tok_alu_pkg;
    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_EQ    = 5'd5,
        OP_LT    = 5'd6,
        OP_LTE   = 5'd7,
        OP_GT    = 5'd8,
        OP_GTE   = 5'd9,
        OP_INC   = 5'd16,
        OP_DEC   = 5'd17,
        OP_NOT   = 5'd18,
        OP_PASS  = 5'd19,
        OP_CONST = 5'd20,
        OP_SHL   = 5'd21,
        OP_SHR   = 5'd22,
        OP_ASR   = 5'd23,
        OP_FREE  = 5'd24
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;
endpackage

// File: rtl/tok_alu_arith.sv
module tok_alu_arith #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum_ab,
    output logic [DATA_W-1:0] diff_ab,
    output logic [DATA_W-1:0] incr_a,
    output logic [DATA_W-1:0] decr_a
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        sum_ab  = opa + opb;
        diff_ab = opa - opb;
        incr_a  = opa + ONE;
        decr_a  = opa - ONE;
    end

    always_comb begin
        if (opa == {DATA_W{1'b1}})
            assert (incr_a == '0) else $error("AST_INC_WRAP"); // R2
    end
endmodule

// File: rtl/tok_alu_logic.sv
module tok_alu_logic #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] and_ab,
    output logic [DATA_W-1:0] or_ab,
    output logic [DATA_W-1:0] xor_ab,
    output logic [DATA_W-1:0] not_a,
    output logic              cmp_eq,
    output logic              cmp_lt,
    output logic              cmp_gt
);
    always_comb begin
        and_ab = opa & opb;
        or_ab  = opa | opb;
        xor_ab = opa ^ opb;
        not_a  = ~opa;
        cmp_eq = (opa == opb);
        cmp_lt = (opa < opb);
        cmp_gt = (opa > opb);
    end

    always_comb begin
        assert ($countones({cmp_eq, cmp_lt, cmp_gt}) == 1)
            else $error("AST_CMP_EXCLUSIVE"); // R4
    end
endmodule

// File: rtl/tok_alu_shift.sv
module tok_alu_shift #(
    parameter int DATA_W = 16,
    parameter int DIST_W = 3
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DIST_W-1:0] dist_code,
    output logic [DATA_W-1:0] shl_a,
    output logic [DATA_W-1:0] shr_a,
    output logic [DATA_W-1:0] asr_a
);
    localparam int AMT_W = DIST_W + 1;

    logic [AMT_W-1:0] amount;

    always_comb begin
        amount = {1'b0, dist_code} + AMT_W'(1);
        shl_a  = opa << amount;
        shr_a  = opa >> amount;
        asr_a  = DATA_W'($signed(opa) >>> amount);
    end

    always_comb begin
        assert (shl_a[0] == 1'b0) else $error("AST_SHL_ZERO_FILL");           // R5
        assert (shr_a[DATA_W-1] == 1'b0) else $error("AST_SHR_ZERO_FILL");    // R6
        assert (asr_a[DATA_W-1] == opa[DATA_W-1]) else $error("AST_ASR_SIGN"); // R7
    end
endmodule

// File: rtl/tok_alu_stage.sv
module tok_alu_stage
    import tok_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int DIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_opcode,
    input  logic [DATA_W-1:0] in_opa,
    input  logic [DATA_W-1:0] in_opb,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [DATA_W-1:0] TRUE_W  = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] FALSE_W = '0;

    logic [DATA_W-1:0] sum_ab, diff_ab, incr_a, decr_a;
    logic [DATA_W-1:0] and_ab, or_ab, xor_ab, not_a;
    logic              cmp_eq, cmp_lt, cmp_gt;
    logic [DATA_W-1:0] shl_a, shr_a, asr_a;
    logic [DATA_W-1:0] result;
    logic              produces;
    out_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    tok_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .opa(in_opa), .opb(in_opb),
        .sum_ab(sum_ab), .diff_ab(diff_ab), .incr_a(incr_a), .decr_a(decr_a)
    );

    tok_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .opa(in_opa), .opb(in_opb),
        .and_ab(and_ab), .or_ab(or_ab), .xor_ab(xor_ab), .not_a(not_a),
        .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .cmp_gt(cmp_gt)
    );

    tok_alu_shift #(.DATA_W(DATA_W), .DIST_W(DIST_W)) u_shift (
        .opa(in_opa), .dist_code(in_imm[DIST_W-1:0]),
        .shl_a(shl_a), .shr_a(shr_a), .asr_a(asr_a)
    );

    always_comb begin
        result   = '0;
        produces = 1'b1;
        case (in_opcode)
            OP_ADD:   result = sum_ab;
            OP_SUB:   result = diff_ab;
            OP_AND:   result = and_ab;
            OP_OR:    result = or_ab;
            OP_XOR:   result = xor_ab;
            OP_EQ:    result = cmp_eq ? TRUE_W : FALSE_W;
            OP_LT:    result = cmp_lt ? TRUE_W : FALSE_W;
            OP_LTE:   result = (cmp_lt || cmp_eq) ? TRUE_W : FALSE_W;
            OP_GT:    result = cmp_gt ? TRUE_W : FALSE_W;
            OP_GTE:   result = (cmp_gt || cmp_eq) ? TRUE_W : FALSE_W;
            OP_INC:   result = incr_a;
            OP_DEC:   result = decr_a;
            OP_NOT:   result = not_a;
            OP_PASS:  result = in_opa;
            OP_CONST: result = {{(DATA_W-IMM_W){1'b0}}, in_imm};
            OP_SHL:   result = shl_a;
            OP_SHR:   result = shr_a;
            OP_ASR:   result = asr_a;
            default:  produces = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = (in_valid && produces) ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = (in_valid && produces) ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (state_d == ST_EMIT) data_q <= result;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_data  = data_q;

    AST_IDLE_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R11
    AST_FREE_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == OP_FREE) |=> !out_valid); // R10
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R10
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode >= 5'd5 && in_opcode <= 5'd9)
        |=> (out_valid && out_data[DATA_W-1:1] == '0)); // R4
    AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == OP_PASS) |=> (out_valid && out_data == $past(in_opa))); // R9
endmodule

// File: tb/tok_alu_stage_bench.sv
module tok_alu_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_opcode = '0;
    logic [15:0] in_opa = '0;
    logic [15:0] in_opb = '0;
    logic [7:0]  in_imm = '0;
    logic        out_valid;
    logic [15:0] out_data;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tok_alu_stage u_tok_alu_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_opa(in_opa), .in_opb(in_opb), .in_imm(in_imm),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [16:0] model(input logic [4:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic [7:0] imm);
        int d;
        d = int'(imm[2:0]) + 1;
        case (op)
            5'd0:  return {1'b1, 16'(a + b)};
            5'd1:  return {1'b1, 16'(a - b)};
            5'd2:  return {1'b1, a & b};
            5'd3:  return {1'b1, a | b};
            5'd4:  return {1'b1, a ^ b};
            5'd5:  return {1'b1, 15'd0, a == b};
            5'd6:  return {1'b1, 15'd0, a < b};
            5'd7:  return {1'b1, 15'd0, a <= b};
            5'd8:  return {1'b1, 15'd0, a > b};
            5'd9:  return {1'b1, 15'd0, a >= b};
            5'd16: return {1'b1, 16'(a + 16'd1)};
            5'd17: return {1'b1, 16'(a - 16'd1)};
            5'd18: return {1'b1, ~a};
            5'd19: return {1'b1, a};
            5'd20: return {1'b1, 8'd0, imm};
            5'd21: return {1'b1, 16'(a << d)};
            5'd22: return {1'b1, 16'(a >> d)};
            5'd23: return {1'b1, 16'($signed(a) >>> d)};
            default: return 17'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction, then idle; check the token one cycle later.
    task automatic run_op(input string req, input logic [4:0] op, input logic [15:0] a,
                          input logic [15:0] b, input logic [7:0] imm);
        logic [16:0] e;
        logic [15:0] prev;
        e = model(op, a, b, imm);
        @(negedge clk);
        prev = out_data;
        in_valid = 1'b1; in_opcode = op; in_opa = a; in_opb = b; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {15'd0, out_valid}, {15'd0, e[16]});
        check(req, out_data, e[16] ? e[15:0] : prev);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", {15'd0, out_valid}, 16'd0);
    endtask

    task automatic t_arith;
        run_op("R2", 5'd0, 16'hFFFF, 16'h0002, 8'd0);
        run_op("R2", 5'd1, 16'h0001, 16'h0003, 8'd0);
        run_op("R2", 5'd16, 16'hFFFF, 16'h0000, 8'd0);
        run_op("R2", 5'd17, 16'h0000, 16'h0000, 8'd0);
    endtask

    task automatic t_logic;
        run_op("R3", 5'd2, 16'hF0F0, 16'hFF00, 8'd0);
        run_op("R3", 5'd3, 16'hF0F0, 16'h0F00, 8'd0);
        run_op("R3", 5'd4, 16'hAAAA, 16'hFFFF, 8'd0);
        run_op("R3", 5'd18, 16'h1234, 16'h0000, 8'd0);
    endtask

    task automatic t_compare;
        run_op("R4", 5'd5, 16'h5555, 16'h5555, 8'd0);
        run_op("R4", 5'd5, 16'h5555, 16'h5554, 8'd0);
        run_op("R4", 5'd6, 16'h0001, 16'h8000, 8'd0);
        run_op("R4", 5'd6, 16'h8000, 16'h0001, 8'd0);
        run_op("R4", 5'd7, 16'h7777, 16'h7777, 8'd0);
        run_op("R4", 5'd8, 16'hFFFF, 16'h0000, 8'd0);
        run_op("R4", 5'd9, 16'h0003, 16'h0004, 8'd0);
        run_op("R4", 5'd9, 16'h0004, 16'h0004, 8'd0);
    endtask

    task automatic t_shifts;
        run_op("R5", 5'd21, 16'h8181, 16'h0, 8'd0);
        run_op("R5", 5'd21, 16'h00FF, 16'h0, 8'd7);
        run_op("R5", 5'd21, 16'h0001, 16'h0, 8'hFB);
        run_op("R6", 5'd22, 16'h8000, 16'h0, 8'd0);
        run_op("R6", 5'd22, 16'hFFFF, 16'h0, 8'd7);
        run_op("R7", 5'd23, 16'h8000, 16'h0, 8'd0);
        run_op("R7", 5'd23, 16'hF000, 16'h0, 8'd7);
        run_op("R7", 5'd23, 16'h7F00, 16'h0, 8'd3);
    endtask

    task automatic t_data;
        run_op("R8", 5'd19, 16'hBEEF, 16'h1111, 8'd0);
        run_op("R8", 5'd20, 16'hFFFF, 16'hFFFF, 8'hA5);
    endtask

    task automatic t_backtoback;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = 5'd0; in_opa = 16'd10; in_opb = 16'd20;
        @(negedge clk);
        check("R9", {15'd0, out_valid}, 16'd1);
        check("R9", out_data, 16'd30);
        in_opcode = 5'd1; in_opa = 16'd5; in_opb = 16'd7;
        @(negedge clk);
        check("R9", {15'd0, out_valid}, 16'd1);
        check("R9", out_data, 16'hFFFE);
        in_valid = 1'b0;
        @(negedge clk);
        check("R11", {15'd0, out_valid}, 16'd0);
        check("R11", out_data, 16'hFFFE);
    endtask

    task automatic t_silent;
        run_op("R8", 5'd19, 16'h4242, 16'h0, 8'd0);
        run_op("R10", 5'd24, 16'h9999, 16'h0, 8'd0);
        run_op("R10", 5'd12, 16'h9999, 16'h9999, 8'd0);
        run_op("R10", 5'd31, 16'h9999, 16'h9999, 8'd0);
        check("R10", out_data, 16'h4242);
        @(negedge clk);
        in_valid = 1'b0; in_opcode = 5'd19; in_opa = 16'h1357;
        @(negedge clk);
        check("R11", {15'd0, out_valid}, 16'd0);
        check("R11", out_data, 16'h4242);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_reset;
        t_arith;
        t_logic;
        t_compare;
        t_shifts;
        t_data;
        t_backtoback;
        t_silent;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule